// File: doc/BRIEF.md
# Prescaled Timer/Counter with Edge-Triggered Clear

This block is a free-running up-counter with a programmable prescaler, built for a bus-clocked peripheral area. An 8-bit control value picks the count source at run time. In timer mode a prescale counter runs on every clock and advances the main counter each time it reaches the programmed prescale limit. In the three counter modes the prescaler is bypassed and the main counter advances on rising, falling or both edges of one of four external capture pins. All four pins are resynchronised into the clock domain before use.

Independently of the count source, an optional clear event zeroes both the main counter and the prescale counter. The event is a chosen edge on a chosen capture pin. A small register port sets the control value and the prescale limit, preloads the main counter and reads every register back. A count enable gates all counting.

Top module: `tmr_edge_clr`

## Requirements
- R1: After reset the control value, prescale limit, main counter and prescale counter all read 0, which selects timer mode with no clear.
- R2: In timer mode (control bits 1:0 = 0) with enable high, the prescale counter rises by one per clock. On a clock where it equals the prescale limit, it returns to 0 instead and the main counter rises by one, so the main counter advances once every limit+1 clocks.
- R3: With enable low, neither the main counter nor the prescale counter changes, whatever the mode.
- R4: Control bits 1:0 = 1, 2 or 3 count rising, falling or both edges of the selected pin. Each such edge adds one to the main counter on the third rising clock edge after the pin changes, and the prescale counter holds its value.
- R5: Control bits 3:2 give the number (0..3) of the pin counted in counter modes, and edges on the other pins do not change the count.
- R6: With control bit 4 set, an edge on pin number bits 7:6 clears the main counter and the prescale counter to 0 on the third rising clock edge after the pin changes. A falling edge is used when bit 5 is 1 and a rising edge when bit 5 is 0.
- R7: While control bit 4 is 0, the edge selected by bits 7:5 has no effect on either counter.
- R8: When a clear event and a count event fall on the same clock, the clear wins and the main counter becomes 0.
- R9: The main counter wraps from its maximum value (all ones) to 0.
- R10: The register port uses address 0 for control (low 8 bits, upper bits read 0), 1 for prescale limit, 2 for main counter (a write preloads it) and 3 for prescale counter (read only). A write takes effect at the next clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable |
| cap_in | input | 4 | Asynchronous capture pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | WIDTH | Register read data |

## Verification
A count event and a clear event can fall on the same clock. This happens when counter mode counts rising edges of pin 0 and the clear is also armed on the rising edge of pin 0. The bench preloads a non-zero count and raises that pin once. Three clock edges later the main counter must read 0, not the preload plus one. A second scenario holds a count of 100 through a rising edge that is not the armed one. It then checks that the armed falling edge zeroes both counters in exactly the expected cycle.

// File: rtl/tmr_edge_clr.sv
module tmr_edge_clr #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       cap_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [7:0]       ctrl;
  logic [WIDTH-1:0] lim, cnt, pre;
  logic [3:0]       s1, s2, dly;

  wire [1:0] mode     = ctrl[1:0];
  wire [1:0] src      = ctrl[3:2];
  wire       clr_on   = ctrl[4];
  wire       clr_fall = ctrl[5];
  wire [1:0] clr_ch   = ctrl[7:6];

  wire [3:0] rise = s2 & ~dly;
  wire [3:0] fall = ~s2 & dly;

  wire timer_mode = (mode == 2'd0);
  wire pre_hit    = (pre == lim);
  wire cnt_edge   = (mode[0] & rise[src]) | (mode[1] & fall[src]);
  wire clr_evt    = clr_on & (clr_fall ? fall[clr_ch] : rise[clr_ch]);
  wire inc        = en & (timer_mode ? pre_hit : cnt_edge);
  wire cnt_wr     = wr_en & (wr_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      lim  <= '0;
      cnt  <= '0;
      pre  <= '0;
      s1   <= '0;
      s2   <= '0;
      dly  <= '0;
    end else begin
      s1  <= cap_in;
      s2  <= s1;
      dly <= s2;
      if (wr_en && wr_addr == 2'd0) ctrl <= wr_data[7:0];
      if (wr_en && wr_addr == 2'd1) lim  <= wr_data;
      if (cnt_wr)       cnt <= wr_data;
      else if (clr_evt) cnt <= '0;
      else if (inc)     cnt <= cnt + 1'b1;
      if (clr_evt) pre <= '0;
      else if (en && timer_mode) pre <= pre_hit ? '0 : pre + 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {{(WIDTH-8){1'b0}}, ctrl};
      2'd1:    rd_data = lim;
      2'd2:    rd_data = cnt;
      default: rd_data = pre;
    endcase
  end

  // R6
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !cnt_wr) |=> (cnt == '0 && pre == '0));

  // R8
  clear_beats_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && inc && !cnt_wr) |=> (cnt == '0));

  // R2
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && timer_mode && pre_hit && !clr_evt && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1 && pre == '0));

  // R2
  prescale_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && timer_mode && !pre_hit && !clr_evt) |=> (pre == $past(pre) + 1'b1));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr_evt && !cnt_wr) |=> ($stable(cnt) && $stable(pre)));

  // R4
  counter_mode_prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_mode && !clr_evt) |=> $stable(pre));

  // R7
  clear_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on && !inc && !cnt_wr) |=> $stable(cnt));

endmodule

// File: tb/tmr_edge_clr_bench.sv
`timescale 1ns/1ps
module tmr_edge_clr_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic [3:0]  cap_in = '0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  tmr_edge_clr #(.WIDTH(32)) u_tmr_edge_clr (
    .clk(clk), .rst_n(rst_n), .en(en), .cap_in(cap_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); cap_in[ch] = 1'b1;
    repeat (5) @(negedge clk);
    cap_in[ch] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reset", v, 32'h0);
    end
  endtask

  task automatic t_timer;
    logic [31:0] v;
    wr(2'd1, 32'd2);
    en = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R2 timer count", v, 32'd3);
    rd(2'd3, v); chk("R2 prescale count", v, 32'd1);
    en = 0;
    repeat (6) @(negedge clk);
    rd(2'd2, v); chk("R3 hold count", v, 32'd3);
    rd(2'd3, v); chk("R3 hold prescale", v, 32'd1);
  endtask

  task automatic t_counter;
    logic [31:0] v;
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h09);
    en = 1;
    pulse(0);
    rd(2'd2, v); chk("R5 other pin ignored", v, 32'd0);
    pulse(2);
    rd(2'd2, v); chk("R4 rising count", v, 32'd1);
    rd(2'd3, v); chk("R4 prescale held", v, 32'd1);
    wr(2'd0, 32'h0A);
    pulse(2);
    rd(2'd2, v); chk("R4 falling count", v, 32'd2);
    wr(2'd0, 32'h0B);
    pulse(2);
    rd(2'd2, v); chk("R4 both edges count", v, 32'd4);
    en = 0;
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(2'd0, 32'h70);
    wr(2'd1, 32'd1000);
    wr(2'd2, 32'd100);
    en = 1;
    @(negedge clk); cap_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R6 wrong edge keeps count", v, 32'd100);
    cap_in[1] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R6 count cleared", v, 32'd0);
    rd(2'd3, v); chk("R6 prescale cleared", v, 32'd0);
    @(negedge clk);
    rd(2'd3, v); chk("R6 prescale restarts", v, 32'd1);
    en = 0;
  endtask

  task automatic t_clear_off;
    logic [31:0] v;
    wr(2'd0, 32'h60);
    wr(2'd2, 32'd50);
    pulse(1);
    rd(2'd2, v); chk("R7 clear disabled", v, 32'd50);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    wr(2'd0, 32'h11);
    wr(2'd2, 32'd5);
    en = 1;
    @(negedge clk); cap_in[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R8 clear beats count", v, 32'd0);
    cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    en = 0;
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'hFFFF_FFFE);
    en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    en = 0;
    rd(2'd2, v); chk("R9 wrap", v, 32'd1);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(2'd0, 32'h1FF);
    rd(2'd0, v); chk("R10 control width", v, 32'hFF);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h1234);
    rd(2'd1, v); chk("R10 prescale limit", v, 32'h1234);
    wr(2'd3, 32'h55);
    rd(2'd3, v); chk("R10 prescale counter read only", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_timer;
    t_counter;
    t_clear;
    t_clear_off;
    t_same_cycle;
    t_wrap;
    t_regs;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule